// File: doc/BRIEF.md
# Reset Source Capture Register

This block merges a set of reset requests into one system reset and keeps an 8-bit status register that names the source of the most recent reset. The register sits on a simple special-function-register bus. A read returns one-hot cause flags. A write to the same bit positions does not change those flags. Instead it switches the optional sources (supply monitor, missing-clock detector, comparator) on or off, or forces a software reset.

The request inputs are single-cycle or level strobes from circuits outside this block. These are an external pin request, a supply-monitor trip, a missing-clock timeout, a watchdog timeout, an active-low comparator output and a flash error strobe. The asynchronous active-low `rst_n` is the power-on reset and is assumed to be released in step with `clk`.

Once a request is accepted, the system reset stays high for a fixed stretch, set by the parameter `STRETCH_CYC` (default 4). The block accepts no new request and no bus write until that stretch ends. Software should write the register with a plain write and not with a read-modify-write. Writing back a read value that has bit 4 set forces a reset.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Read bit 7 is always 1; writes to bit 7 have no effect on any state.
- R2: While `rst_n` is low, `sys_rst` is 1 and the read data is 0x82. After `rst_n` rises, `sys_rst` stays 1 for exactly 4 more clock cycles. The power-on reset disables the comparator and missing-clock sources and enables the supply-monitor source.
- R3: A request accepted at a clock edge raises `sys_rst` after that edge and holds it for exactly 4 cycles. Requests and bus writes that arrive while `sys_rst` is 1 are not accepted.
- R4: The cause bits [6:0] are always one-hot and change only on the edge where `sys_rst` rises. When several requests arrive together, the lowest bit position wins.
- R5: Read-only sources, each of which sets only its own flag: external pin sets bit 0, watchdog sets bit 3, flash error sets bit 6. Writing bits 6, 3 or 0 has no effect.
- R6: A write of 1 to bit 4 at address 0xEF forces a reset and sets flag bit 4. A write of 0 to bit 4 forces nothing.
- R7: A write to bit 5 enables (1) or disables (0) the comparator as a source. When it is enabled, a low `cmp_out` causes a reset and sets flag bit 5.
- R8: A write to bit 2 enables (1) or disables (0) the missing-clock timeout as a source. When it causes a reset, it sets flag bit 2.
- R9: A write to bit 1 enables (1) or disables (0) the supply-monitor trip as a source. When it causes a reset, it sets flag bit 1.
- R10: Writes to any address other than 0xEF change no state and force no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| pin_req | input | 1 | External reset pin request |
| sup_trip | input | 1 | Supply-monitor trip |
| mclk_tmo | input | 1 | Missing-clock timeout |
| wdt_tmo | input | 1 | Watchdog timeout |
| cmp_out | input | 1 | Comparator output; a low level requests a reset when enabled |
| flash_err | input | 1 | Flash access error strobe |
| sfr_wr | input | 1 | Bus write strobe |
| sfr_addr | input | 8 | Bus address |
| sfr_wdata | input | 8 | Bus write data |
| sfr_rdata | output | 8 | Read data: bit 7 = 1, bits [6:0] = cause flags |
| sys_rst | output | 1 | System reset, active high |

## Verification
The three source enables are hidden, so a wrong enable becomes visible only when its source strobes next. Either a reset appears that should not, or one fails to appear, one cycle after the strobe. The bench therefore strobes every optional source both before and after each enable write. A wrong stretch count or a missed busy gate changes the width of `sys_rst` or the read flags, and shows within five cycles of a request. A wrong priority or flag load shows in the read data in the first cycle of the reset.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int NSRC    = 7;
  localparam int B_PIN   = 0;
  localparam int B_SUP   = 1;
  localparam int B_MCLK  = 2;
  localparam int B_WDT   = 3;
  localparam int B_SW    = 4;
  localparam int B_CMP   = 5;
  localparam int B_FLASH = 6;
endpackage

// File: rtl/rcc_src_arb.sv
module rcc_src_arb #(
  parameter int NSRC = 7
) (
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] grant,
  output logic            any
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any = |req;
  end
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int STRETCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  output logic take,
  output logic idle,
  output logic sys_rst
);
  localparam int CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  assign idle    = (cnt_q == '0);
  assign sys_rst = !idle;
  assign take    = idle && req_any;

  always_comb begin
    cnt_d = cnt_q;
    if (!idle)     cnt_d = cnt_q - 1'b1;
    else if (take) cnt_d = LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LOAD;
    else        cnt_q <= cnt_d;
  end

  // checker: length of the current reset pulse
  logic [7:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= '0;
    else if (sys_rst) hi_len <= hi_len + 8'd1;
    else              hi_len <= '0;
  end

  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (hi_len == 8'(STRETCH_CYC)));
  a_r3_take_raises: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> sys_rst);
endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg #(
  parameter int NSRC    = 7,
  parameter int POR_BIT = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [NSRC-1:0] grant,
  input  logic            wr_en,
  input  logic            wd_cmp,
  input  logic            wd_mclk,
  input  logic            wd_sup,
  output logic            en_cmp,
  output logic            en_mclk,
  output logic            en_sup,
  output logic [NSRC:0]   rdata
);
  logic [NSRC-1:0] flags_q, flags_d;
  logic            cmp_d, mclk_d, sup_d;

  always_comb begin
    flags_d = take ? grant : flags_q;
    cmp_d   = wr_en ? wd_cmp  : en_cmp;
    mclk_d  = wr_en ? wd_mclk : en_mclk;
    sup_d   = wr_en ? wd_sup  : en_sup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= NSRC'(1) << POR_BIT;
      en_cmp  <= 1'b0;
      en_mclk <= 1'b0;
      en_sup  <= 1'b1;
    end else begin
      flags_q <= flags_d;
      en_cmp  <= cmp_d;
      en_mclk <= mclk_d;
      en_sup  <= sup_d;
    end
  end

  assign rdata = {1'b1, flags_q};

  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(flags_q));
  a_r10_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_cmp) && $stable(en_mclk) && $stable(en_sup)));
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int          STRETCH_CYC = 4,
  parameter logic [7:0]  REG_ADDR    = 8'hEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_req,
  input  logic       sup_trip,
  input  logic       mclk_tmo,
  input  logic       wdt_tmo,
  input  logic       cmp_out,
  input  logic       flash_err,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output logic       sys_rst
);
  logic [NSRC-1:0] req, grant;
  logic            req_any, take, idle, wr_hit;
  logic            en_cmp, en_mclk, en_sup;

  assign wr_hit = sfr_wr && (sfr_addr == REG_ADDR) && idle;

  always_comb begin
    req          = '0;
    req[B_PIN]   = pin_req;
    req[B_SUP]   = sup_trip && en_sup;
    req[B_MCLK]  = mclk_tmo && en_mclk;
    req[B_WDT]   = wdt_tmo;
    req[B_SW]    = wr_hit && sfr_wdata[B_SW];
    req[B_CMP]   = !cmp_out && en_cmp;
    req[B_FLASH] = flash_err;
  end

  rcc_src_arb #(.NSRC(NSRC)) arb_i (
    .req   (req),
    .grant (grant),
    .any   (req_any)
  );

  rcc_stretch #(.STRETCH_CYC(STRETCH_CYC)) str_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_any (req_any),
    .take    (take),
    .idle    (idle),
    .sys_rst (sys_rst)
  );

  rcc_cause_reg #(.NSRC(NSRC), .POR_BIT(B_SUP)) cause_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .grant   (grant),
    .wr_en   (wr_hit),
    .wd_cmp  (sfr_wdata[B_CMP]),
    .wd_mclk (sfr_wdata[B_MCLK]),
    .wd_sup  (sfr_wdata[B_SUP]),
    .en_cmp  (en_cmp),
    .en_mclk (en_mclk),
    .en_sup  (en_sup),
    .rdata   (sfr_rdata)
  );

  a_r1_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rdata[7]);
  a_r4_onehot_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sfr_rdata[6:0]) == 1);
  a_r6_sw_force: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == REG_ADDR && sfr_wdata[B_SW] && !sys_rst)
      |=> (sys_rst && $countones(sfr_rdata[6:0]) == 1));
  a_r5_pin_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_req && !sys_rst) |=> (sys_rst && sfr_rdata[B_PIN]));
endmodule

// File: tb/rst_cause_ctrl_tb_top.sv
module rst_cause_ctrl_tb_top;
  localparam int CLK_PER = 10;

  logic clk, rst_n;
  logic pin_req, sup_trip, mclk_tmo, wdt_tmo, cmp_out, flash_err, sfr_wr;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic sys_rst;

  int n_chk, n_fail, cyc;
  int m_cnt, m_flags, m_en_cmp, m_en_mclk, m_en_sup;

  rst_cause_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .sup_trip(sup_trip),
    .mclk_tmo(mclk_tmo), .wdt_tmo(wdt_tmo), .cmp_out(cmp_out),
    .flash_err(flash_err), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sys_rst(sys_rst)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 4; m_flags = 8'h02;
      m_en_cmp = 0; m_en_mclk = 0; m_en_sup = 1;
    end else if (m_cnt != 0) begin
      m_cnt = m_cnt - 1;
    end else begin
      int first;
      bit hit;
      bit r [7];
      hit  = sfr_wr && (sfr_addr == 8'hEF);
      r[0] = pin_req;
      r[1] = sup_trip && (m_en_sup != 0);
      r[2] = mclk_tmo && (m_en_mclk != 0);
      r[3] = wdt_tmo;
      r[4] = hit && sfr_wdata[4];
      r[5] = !cmp_out && (m_en_cmp != 0);
      r[6] = flash_err;
      first = -1;
      for (int i = 6; i >= 0; i--) if (r[i]) first = i;
      if (first >= 0) begin
        m_cnt = 4;
        m_flags = 1 << first;
      end
      if (hit) begin
        m_en_cmp  = sfr_wdata[5];
        m_en_mclk = sfr_wdata[2];
        m_en_sup  = sfr_wdata[1];
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk("R3 sys_rst", int'(sys_rst), (m_cnt != 0) ? 1 : 0);
      chk("R4 rdata", int'(sfr_rdata), 8'h80 | m_flags);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  // v: bit0 pin, 1 supply, 2 missing clock, 3 watchdog, 5 comparator low, 6 flash
  task automatic pulse(input logic [6:0] v);
    pin_req = v[0]; sup_trip = v[1]; mclk_tmo = v[2]; wdt_tmo = v[3];
    cmp_out = !v[5]; flash_err = v[6];
    @(negedge clk);
    pin_req = 0; sup_trip = 0; mclk_tmo = 0; wdt_tmo = 0;
    cmp_out = 1; flash_err = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 0; sfr_addr = 0; sfr_wdata = 0;
  endtask

  task automatic wait_idle();
    while (sys_rst) @(negedge clk);
  endtask

  task automatic expect_rst(input string tag, input int rd);
    chk(tag, int'(sys_rst), 1);
    chk(tag, int'(sfr_rdata), rd);
    wait_idle();
  endtask

  initial begin
    int n;
    n_chk = 0; n_fail = 0; cyc = 0;
    rst_n = 0; pin_req = 0; sup_trip = 0; mclk_tmo = 0; wdt_tmo = 0;
    cmp_out = 1; flash_err = 0; sfr_wr = 0; sfr_addr = 0; sfr_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R2 rst during por", int'(sys_rst), 1);
    chk("R2 rdata during por", int'(sfr_rdata), 8'h82);
    rst_n = 1;
    n = 0;
    while (sys_rst) begin @(negedge clk); n++; end
    chk("R2 por stretch", n, 4);
    chk("R2 R1 rdata after por", int'(sfr_rdata), 8'h82);

    // defaults: missing clock and comparator off, supply on
    pulse(7'b0000100); chk("R8 mclk disabled", int'(sys_rst), 0);
    pulse(7'b0100000); chk("R7 cmp disabled", int'(sys_rst), 0);
    pulse(7'b0000010); expect_rst("R9 supply trip", 8'h82);

    pulse(7'b0000001); expect_rst("R5 pin", 8'h81);
    pulse(7'b0001000); expect_rst("R5 watchdog", 8'h88);
    pulse(7'b1000000); expect_rst("R5 flash", 8'hC0);

    // plain write with bit4=0 and read-only bits set: no reset, all sources off
    wr(8'hEF, 8'hC9);
    chk("R6 R1 R5 no force", int'(sys_rst), 0);
    chk("R5 flags untouched", int'(sfr_rdata), 8'hC0);
    pulse(7'b0000010); chk("R9 supply disabled", int'(sys_rst), 0);

    wr(8'hEF, 8'h10); expect_rst("R6 sw reset", 8'h90);

    wr(8'h10, 8'h10); chk("R10 other addr", int'(sys_rst), 0);
    wr(8'h10, 8'h24);
    pulse(7'b0000100); chk("R10 enable not set", int'(sys_rst), 0);

    wr(8'hEF, 8'h24);
    pulse(7'b0000100); expect_rst("R8 mclk", 8'h84);
    pulse(7'b0100000); expect_rst("R7 cmp", 8'hA0);
    // comparator held low: fires again once the stretch ends
    cmp_out = 0; @(negedge clk);
    chk("R7 held low", int'(sys_rst), 1);
    wait_idle(); @(negedge clk);
    chk("R7 refire", int'(sys_rst), 1);
    cmp_out = 1; wait_idle();

    pulse(7'b0001001); expect_rst("R4 priority pin over wdt", 8'h81);
    pulse(7'b1001000); expect_rst("R4 priority wdt over flash", 8'h88);

    // requests and writes during the stretch are not taken
    pulse(7'b0000001);
    pulse(7'b1000000);
    wr(8'hEF, 8'h10);
    wr(8'hEF, 8'h00);
    wait_idle();
    chk("R3 busy ignored", int'(sfr_rdata), 8'h81);
    @(negedge clk);
    chk("R3 no late reset", int'(sys_rst), 0);
    pulse(7'b0000100); expect_rst("R3 enable kept", 8'h84);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule